// File: doc/BRIEF.md
# Next-PC and Branch Resolution Unit

This unit picks the address of the next instruction from a single instruction-class code. It handles six cases: sequential flow, compare-against-zero branches in both senses, condition-code branches that read the four arithmetic flags, unconditional relative jumps, register-indirect jumps, and relative calls that also write a return address.

Relative displacements count instructions, not bytes. The unit sign-extends the displacement and scales it by four. It then adds the result to the address of the following instruction, which is the current address plus four. A call also asks for a write of that following address into link register 30.

Results are registered, so they appear one clock after the request. Fetch, decode and hazard handling happen elsewhere.

Top module: `npc_resolve`

## Requirements
- R1: While `rst_ni` is low, `valid_o`, `taken_o` and `link_we_o` are 0, and `next_pc_o` and `link_data_o` are 0.
- R2: Every result appears on the clock edge after its request, and `valid_o` follows `valid_i` one cycle late. A cycle with `valid_i` low gives `valid_o`, `taken_o` and `link_we_o` all at 0.
- R3: Class 0 (sequential) and the unused class 7 give `next_pc_o` = PC+4 with `taken_o` = 0.
- R4: Class 1 (branch if zero) is taken only when `reg_val_i` is 0. Its target is PC+4+4·sext(offset_i[18:0]).
- R5: Class 2 (branch if non-zero) is taken only when `reg_val_i` is not 0. It uses the same 19-bit target as R4.
- R6: Class 3 (conditional branch) reads `flags_i` = {N,Z,C,V} and `cond_i`, and is taken when the selected condition holds. The conditions are: 0 Z; 1 !Z; 2 C; 3 !C; 4 N; 5 !N; 6 V; 7 !V; 8 C&!Z; 9 !C|Z; 10 N==V; 11 N!=V; 12 !Z&(N==V); 13 Z|(N!=V). Its target is the 19-bit target of R4.
- R7: Condition codes 14 and 15 are always taken, whatever the flags.
- R8: Class 4 (jump) is always taken to PC+4+4·sext(offset_i[25:0]). For classes 1 to 3, bits 25:19 of `offset_i` have no effect.
- R9: Class 5 (register jump) is always taken, with `next_pc_o` = `reg_val_i`.
- R10: Class 6 (call) is taken to the 26-bit target of R8. It sets `link_we_o` = 1, `link_idx_o` = 30 and `link_data_o` = PC+4.
- R11: A branch that is not taken gives `next_pc_o` = PC+4.
- R12: `link_we_o` is 1 only for a valid class-6 request.
- R13: All address sums wrap modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request valid |
| kind_i | input | 3 | Instruction class (0..7) |
| pc_i | input | ADDR_W | Address of the current instruction |
| offset_i | input | LONG_OFF_W | Signed displacement in instructions |
| reg_val_i | input | ADDR_W | Register operand for the zero test or the indirect jump |
| flags_i | input | 4 | Flags {N,Z,C,V} |
| cond_i | input | 4 | Condition selector |
| valid_o | output | 1 | Result valid |
| next_pc_o | output | ADDR_W | Next instruction address |
| taken_o | output | 1 | Redirect away from PC+4 |
| link_we_o | output | 1 | Link register write enable |
| link_idx_o | output | REG_IDX_W | Link register index (30) |
| link_data_o | output | ADDR_W | Return address to write |

## Verification
The bound checker watches the control rules on every cycle, and it also checks those address results that follow from a single past input:
- an idle cycle stays quiet;
- the link write happens only for calls;
- register jumps land on the operand;
- sequential and not-taken requests land on PC+4;
- always-conditions are taken;
- the zero test follows the operand.

The scenarios carry the arithmetic that the properties cannot reach:
- every condition code against every flag pattern;
- negative displacements in both field widths;
- the upper offset bits that short branches ignore;
- address wrap at the top of the space.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [2:0] {
    K_SEQ   = 3'd0,
    K_CBZ   = 3'd1,
    K_CBNZ  = 3'd2,
    K_BCOND = 3'd3,
    K_B     = 3'd4,
    K_BR    = 3'd5,
    K_BL    = 3'd6,
    K_RSVD  = 3'd7
  } npc_kind_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  localparam int unsigned INSN_BYTES = 4;
  localparam int unsigned SCALE_SH   = 2;
endpackage

// File: rtl/npc_cond_eval.sv
module npc_cond_eval
  import npc_pkg::*;
(
  input  logic [3:0] flags_i,
  input  logic [3:0] cond_i,
  output logic       hold_o
);
  nzcv_t f;
  logic  base;

  assign f = nzcv_t'(flags_i);

  // cond[3:1] picks the test, cond[0] inverts it (except the always pair)
  always_comb begin
    unique case (cond_i[3:1])
      3'd0:    base = f.z;
      3'd1:    base = f.c;
      3'd2:    base = f.n;
      3'd3:    base = f.v;
      3'd4:    base = f.c & ~f.z;
      3'd5:    base = f.n ~^ f.v;
      3'd6:    base = ~f.z & (f.n ~^ f.v);
      default: base = 1'b1;
    endcase
  end

  assign hold_o = (cond_i[3:1] == 3'd7) ? 1'b1 : (base ^ cond_i[0]);
endmodule

// File: rtl/npc_rel_target.sv
module npc_rel_target
  import npc_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned OFF_W  = 26
) (
  input  logic [ADDR_W-1:0] seq_pc_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [ADDR_W-1:0] target_o
);
  localparam int unsigned EXT_W = ADDR_W - OFF_W - SCALE_SH;

  logic [ADDR_W-1:0] byte_off;

  generate
    if (EXT_W > 0) begin : g_ext
      assign byte_off = {{EXT_W{off_i[OFF_W-1]}}, off_i, {SCALE_SH{1'b0}}};
    end else begin : g_trunc
      logic [OFF_W+SCALE_SH-1:0] full;
      assign full     = {off_i, {SCALE_SH{1'b0}}};
      assign byte_off = full[ADDR_W-1:0];
    end
  endgenerate

  assign target_o = seq_pc_i + byte_off;
endmodule

// File: rtl/npc_branch_decide.sv
module npc_branch_decide
  import npc_pkg::*;
#(
  parameter int unsigned ADDR_W = 64
) (
  input  npc_kind_e         kind_i,
  input  logic              reg_zero_i,
  input  logic              cond_hold_i,
  input  logic [ADDR_W-1:0] seq_pc_i,
  input  logic [ADDR_W-1:0] short_tgt_i,
  input  logic [ADDR_W-1:0] long_tgt_i,
  input  logic [ADDR_W-1:0] reg_val_i,
  output logic              taken_o,
  output logic              link_o,
  output logic [ADDR_W-1:0] npc_o
);
  always_comb begin
    taken_o = 1'b0;
    link_o  = 1'b0;
    unique case (kind_i)
      K_CBZ:   taken_o = reg_zero_i;
      K_CBNZ:  taken_o = ~reg_zero_i;
      K_BCOND: taken_o = cond_hold_i;
      K_B,
      K_BR:    taken_o = 1'b1;
      K_BL: begin
        taken_o = 1'b1;
        link_o  = 1'b1;
      end
      default: taken_o = 1'b0;
    endcase
  end

  always_comb begin
    if (!taken_o)                         npc_o = seq_pc_i;
    else if (kind_i == K_BR)              npc_o = reg_val_i;
    else if (kind_i == K_B || kind_i == K_BL) npc_o = long_tgt_i;
    else                                  npc_o = short_tgt_i;
  end
endmodule

// File: rtl/npc_resolve.sv
module npc_resolve
  import npc_pkg::*;
#(
  parameter int unsigned ADDR_W      = 64,
  parameter int unsigned LONG_OFF_W  = 26,
  parameter int unsigned SHORT_OFF_W = 19,
  parameter int unsigned REG_IDX_W   = 5,
  parameter int unsigned LINK_REG    = 30
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic [2:0]            kind_i,
  input  logic [ADDR_W-1:0]     pc_i,
  input  logic [LONG_OFF_W-1:0] offset_i,
  input  logic [ADDR_W-1:0]     reg_val_i,
  input  logic [3:0]            flags_i,
  input  logic [3:0]            cond_i,
  output logic                  valid_o,
  output logic [ADDR_W-1:0]     next_pc_o,
  output logic                  taken_o,
  output logic                  link_we_o,
  output logic [REG_IDX_W-1:0]  link_idx_o,
  output logic [ADDR_W-1:0]     link_data_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

  npc_kind_e         kind;
  logic [ADDR_W-1:0] seq_pc, short_tgt, long_tgt, npc_d;
  logic              reg_zero, cond_hold, taken_d, link_d;

  logic              valid_q, taken_q, link_we_q;
  logic [ADDR_W-1:0] next_pc_q, link_data_q;

  assign kind     = npc_kind_e'(kind_i);
  assign seq_pc   = pc_i + STEP;
  assign reg_zero = ~|reg_val_i;

  npc_cond_eval u_cond (
    .flags_i (flags_i),
    .cond_i  (cond_i),
    .hold_o  (cond_hold)
  );

  npc_rel_target #(.ADDR_W(ADDR_W), .OFF_W(SHORT_OFF_W)) u_short_tgt (
    .seq_pc_i (seq_pc),
    .off_i    (offset_i[SHORT_OFF_W-1:0]),
    .target_o (short_tgt)
  );

  npc_rel_target #(.ADDR_W(ADDR_W), .OFF_W(LONG_OFF_W)) u_long_tgt (
    .seq_pc_i (seq_pc),
    .off_i    (offset_i),
    .target_o (long_tgt)
  );

  npc_branch_decide #(.ADDR_W(ADDR_W)) u_decide (
    .kind_i      (kind),
    .reg_zero_i  (reg_zero),
    .cond_hold_i (cond_hold),
    .seq_pc_i    (seq_pc),
    .short_tgt_i (short_tgt),
    .long_tgt_i  (long_tgt),
    .reg_val_i   (reg_val_i),
    .taken_o     (taken_d),
    .link_o      (link_d),
    .npc_o       (npc_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q     <= 1'b0;
      taken_q     <= 1'b0;
      link_we_q   <= 1'b0;
      next_pc_q   <= '0;
      link_data_q <= '0;
    end else begin
      valid_q   <= valid_i;
      taken_q   <= valid_i & taken_d;
      link_we_q <= valid_i & link_d;
      if (valid_i) begin
        next_pc_q   <= npc_d;
        link_data_q <= seq_pc;
      end
    end
  end

  assign valid_o     = valid_q;
  assign taken_o     = taken_q;
  assign link_we_o   = link_we_q;
  assign next_pc_o   = next_pc_q;
  assign link_data_o = link_data_q;
  assign link_idx_o  = REG_IDX_W'(LINK_REG);
endmodule

// File: rtl/npc_resolve_chk.sv
module npc_resolve_chk
  import npc_pkg::*;
#(
  parameter int unsigned ADDR_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [2:0]        kind_i,
  input logic [ADDR_W-1:0] pc_i,
  input logic [ADDR_W-1:0] reg_val_i,
  input logic [3:0]        cond_i,
  input logic              valid_o,
  input logic [ADDR_W-1:0] next_pc_o,
  input logic              taken_o,
  input logic              link_we_o,
  input logic [ADDR_W-1:0] link_data_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

  p_reset_quiet_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && !taken_o && !link_we_o));

  p_valid_follow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && !taken_o && !link_we_o));

  p_seq_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (kind_i == K_SEQ || kind_i == K_RSVD))
      |=> (!taken_o && next_pc_o == $past(pc_i) + STEP));

  p_cbz_test_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && kind_i == K_CBZ) |=> (taken_o == ($past(reg_val_i) == '0)));

  p_always_cond_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && kind_i == K_BCOND && cond_i[3:1] == 3'd7) |=> taken_o);

  p_reg_jump_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && kind_i == K_BR) |=> (taken_o && next_pc_o == $past(reg_val_i)));

  p_link_data_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && kind_i == K_BL) |=> (link_we_o && link_data_o == $past(pc_i) + STEP));

  p_untaken_step_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (taken_o || next_pc_o == $past(pc_i) + STEP));

  p_link_only_call_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && kind_i != K_BL) |=> !link_we_o);
endmodule

bind npc_resolve npc_resolve_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .kind_i      (kind_i),
  .pc_i        (pc_i),
  .reg_val_i   (reg_val_i),
  .cond_i      (cond_i),
  .valid_o     (valid_o),
  .next_pc_o   (next_pc_o),
  .taken_o     (taken_o),
  .link_we_o   (link_we_o),
  .link_data_o (link_data_o)
);

// File: tb/npc_resolve_test.sv
module npc_resolve_test;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    int          stamp;
    logic        vld;
    logic [63:0] npc;
    logic        taken;
    logic        lwe;
    logic [63:0] ldata;
    logic [31:0] req;
  } exp_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  kind_i = '0;
  logic [63:0] pc_i = '0;
  logic [25:0] offset_i = '0;
  logic [63:0] reg_val_i = '0;
  logic [3:0]  flags_i = '0;
  logic [3:0]  cond_i = '0;
  logic        valid_o, taken_o, link_we_o;
  logic [63:0] next_pc_o, link_data_o;
  logic [4:0]  link_idx_o;

  int   checks = 0;
  int   errors = 0;
  int   cyc = 0;
  exp_t q[$];

  npc_resolve uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .kind_i(kind_i),
    .pc_i(pc_i), .offset_i(offset_i), .reg_val_i(reg_val_i),
    .flags_i(flags_i), .cond_i(cond_i), .valid_o(valid_o),
    .next_pc_o(next_pc_o), .taken_o(taken_o), .link_we_o(link_we_o),
    .link_idx_o(link_idx_o), .link_data_o(link_data_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;
  always @(posedge clk_i) if (rst_ni) cyc <= cyc + 1;

  task automatic chk(input logic ok, input logic [31:0] req,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic cond_ok(input logic [3:0] c, input logic [3:0] fl);
    logic n, z, cf, v;
    {n, z, cf, v} = fl;
    case (c)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return cf;
      4'd3:  return !cf;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return cf && !z;
      4'd9:  return !cf || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [63:0] rel(input logic [63:0] pc, input logic [25:0] off,
                                      input bit long_f);
    longint s;
    if (long_f) s = longint'($signed(off));
    else        s = longint'($signed(off[18:0]));
    return pc + 64'd4 + 64'(s * 4);
  endfunction

  task automatic drive(input logic vld, input logic [2:0] k, input logic [63:0] pc,
                       input logic [25:0] off, input logic [63:0] rv,
                       input logic [3:0] fl, input logic [3:0] cd,
                       input logic [31:0] req);
    exp_t e;
    logic tk;
    @(negedge clk_i);
    valid_i = vld; kind_i = k; pc_i = pc; offset_i = off;
    reg_val_i = rv; flags_i = fl; cond_i = cd;
    case (k)
      3'd1: tk = (rv == 0);
      3'd2: tk = (rv != 0);
      3'd3: tk = cond_ok(cd, fl);
      3'd4, 3'd5, 3'd6: tk = 1'b1;
      default: tk = 1'b0;
    endcase
    e.stamp = cyc;
    e.vld   = vld;
    e.taken = vld && tk;
    e.lwe   = vld && (k == 3'd6);
    e.ldata = pc + 64'd4;
    e.req   = req;
    if (!tk)                    e.npc = pc + 64'd4;
    else if (k == 3'd5)         e.npc = rv;
    else if (k == 3'd4 || k == 3'd6) e.npc = rel(pc, off, 1'b1);
    else                        e.npc = rel(pc, off, 1'b0);
    q.push_back(e);
  endtask

  // monitor: pop every item whose result is now on the outputs
  always @(negedge clk_i) begin
    while (q.size() > 0 && q[0].stamp < cyc) begin
      exp_t e;
      e = q.pop_front();
      chk(valid_o == e.vld, "R2", 64'(valid_o), 64'(e.vld));
      chk(taken_o == e.taken, e.req, 64'(taken_o), 64'(e.taken));
      chk(link_we_o == e.lwe, "R12", 64'(link_we_o), 64'(e.lwe));
      if (e.vld) chk(next_pc_o == e.npc, e.req, next_pc_o, e.npc);
      if (e.lwe) begin
        chk(link_data_o == e.ldata, "R10", link_data_o, e.ldata);
        chk(link_idx_o == 5'd30, "R10", 64'(link_idx_o), 64'd30);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    chk(valid_o == 0, "R1", 64'(valid_o), 0);
    chk(taken_o == 0, "R1", 64'(taken_o), 0);
    chk(link_we_o == 0, "R1", 64'(link_we_o), 0);
    chk(next_pc_o == 0 && link_data_o == 0, "R1", next_pc_o | link_data_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R3 sequential and unused class
    drive(1, 3'd0, 64'h1000, 26'd77, 0, 4'hF, 4'd0, "R3");
    drive(1, 3'd7, 64'h2000, 26'd5, 0, 4'h0, 4'd14, "R3");
    // R4 zero test, taken/untaken, negative offset, ignored upper bits (R8)
    drive(1, 3'd1, 64'h4000, 26'd25, 0, 0, 0, "R4");
    drive(1, 3'd1, 64'h4000, 26'd25, 64'd5, 0, 0, "R11");
    drive(1, 3'd1, 64'h4000, 26'h007FFFF, 0, 0, 0, "R4");
    drive(1, 3'd1, 64'h4000, {7'h7F, 19'd25}, 0, 0, 0, "R8");
    // R5 non-zero test
    drive(1, 3'd2, 64'h8000, 26'd25, 64'h100, 0, 0, "R5");
    drive(1, 3'd2, 64'h8000, 26'd25, 0, 0, 0, "R11");
    drive(1, 3'd2, 64'h8000, {7'h55, 19'h7FFF0}, 64'd1, 0, 0, "R8");
    // R6/R7 every condition against every flag pattern
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 16; f++)
        drive(1, 3'd3, 64'h2_0000, {7'h3A, 19'h7FFFD}, 0, 4'(f), 4'(c),
              (c >= 14) ? "R7" : "R6");
    // R8 long jump
    drive(1, 3'd4, 64'h1_0000, 26'd2500, 0, 0, 0, "R8");
    drive(1, 3'd4, 64'h1_0000, 26'h3FFFFFE, 0, 0, 0, "R8");
    drive(1, 3'd4, 64'h1_0000, 26'h2000000, 0, 0, 0, "R8");
    // R9 register jump
    drive(1, 3'd5, 64'h3000, 26'd9, 64'hDEAD_BEE0, 0, 0, "R9");
    drive(1, 3'd5, 64'h3000, 26'd9, 0, 0, 0, "R9");
    // R10 call
    drive(1, 3'd6, 64'h5000, 26'd2500, 0, 0, 0, "R10");
    drive(1, 3'd6, 64'h5000, 26'h3FFFFFF, 0, 0, 0, "R10");
    // R2/R12 idle cycles with call inputs present
    drive(0, 3'd6, 64'h6000, 26'd1, 0, 0, 0, "R2");
    drive(0, 3'd4, 64'h6000, 26'd1, 0, 0, 0, "R12");
    // R13 wrap at the top of the address space
    drive(1, 3'd0, 64'hFFFF_FFFF_FFFF_FFFC, 0, 0, 0, 0, "R13");
    drive(1, 3'd6, 64'hFFFF_FFFF_FFFF_FFF8, 26'd3, 0, 0, 0, "R13");
    drive(1, 3'd4, 64'h0, 26'h3FFFFFC, 0, 0, 0, "R13");
    drive(0, 3'd0, 0, 0, 0, 0, 0, "R2");
    repeat (4) @(negedge clk_i);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule